// File: doc/BRIEF.md
# Reconfigurable Fixed-Width Booth Multiplier

This block multiplies two signed operands using radix-4 Booth recoding. A single set of Booth partial-product rows is reshaped by a 3-bit mode code. It can return a fixed-width high half of the 8x8 product or of a 4x4 product. It can return two independent 4x4 high halves computed side by side, in a compensated variant or an exact-floor variant. It can also return the complete 16-bit product. The fixed-width modes clear the low columns of the partial-product array before summing and add a constant compensation term. The result therefore stays within one output LSB of the true product without the adder width a full sum would need.

The block is combinational from operands to product. An optional output register (parameter `REG_OUT`, on by default) captures the product and a valid flag on each rising clock edge. A controller in a filter datapath uses the dual modes to run two narrow taps per multiplier. It uses the 8-bit fixed-width mode when accuracy matters and the full mode when the whole product is needed.

Top module: `rfw_booth_mul`

## Requirements
- R1: While `rst` is high at a rising edge, `prod` becomes 0 and `out_valid` becomes 0 after that edge.
- R2: With `REG_OUT`=1, `out_valid` after a rising edge equals `in_valid` sampled at that edge, and `prod` reflects `a`, `b` and `mode` sampled at that same edge.
- R3: Mode code 3'b100 gives `prod` = the exact signed 16-bit product of `a` and `b` (both two's complement).
- R4: Mode codes 3'b101, 3'b110 and 3'b111 give the same result as 3'b100.
- R5: Mode code 3'b000 gives an 8-bit signed result r in `prod[7:0]` with `prod[15:8]` = 0, and |256*r - a*b| < 256.
- R6: When `a` or `b` is zero, `prod` is 0 in every mode.
- R7: Mode code 3'b010 uses only `a[3:0]` and `b[3:0]` as signed 4-bit values. It gives a 4-bit signed result r in `prod[3:0]` with |16*r - P| < 16, where P is their product. `prod[15:4]` = 0, and `a[7:4]` and `b[7:4]` have no effect.
- R8: Mode code 3'b001 gives two lanes. `prod[3:0]` is derived from `a[3:0]`*`b[3:0]`, and `prod[7:4]` is derived from `a[7:4]`*`b[7:4]` (all signed 4-bit). For each lane, |16*r - P| < 16, and `prod[15:8]` = 0.
- R9: Mode code 3'b011 gives the same two lanes as R8, but each lane result is exactly floor(P/16) as a 4-bit signed value, and `prod[15:8]` = 0.
- R10: In modes 3'b001 and 3'b011, the operand nibbles of one lane have no effect on the other lane's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operands on `a`/`b` as a request |
| mode | input | 3 | Configuration code (see R3 to R9) |
| a | input | 8 | Multiplicand, two's complement |
| b | input | 8 | Multiplier (Booth-recoded), two's complement |
| prod | output | 16 | Product or packed lane results |
| out_valid | output | 1 | Qualifies `prod` |

## Verification
Every operand pair is swept in the full and 8-bit fixed-width modes. The full sweep compares against an exact product. The fixed-width sweep bounds the error, which separates a correct compensation constant from a missing or wrong one, since the extremes such as -128 x -128 and -128 x 127 sit at the edges of the error window. The dual and single narrow modes are run over all 256 nibble pairs per lane, with the other lane walking a different permutation. Among them, -8 x -8 exposes the Booth digit -2 on the most negative operand, and mixed-sign pairs separate the floor lane from a rounded or truncated-toward-zero one. Held-lane and zero-operand patterns show that rows crossing the 4-bit boundary stay suppressed and that compensation never leaks into a zero product.

// File: rtl/rfw_booth_pkg.sv
package rfw_booth_pkg;

  typedef enum logic [2:0] {
    MD_FIX8       = 3'd0,
    MD_DUAL_CMP   = 3'd1,
    MD_FIX4       = 3'd2,
    MD_DUAL_EXACT = 3'd3,
    MD_FULL       = 3'd4
  } mode_e;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } bdig_t;

  // Unused codes fall back to the full-precision configuration.
  function automatic mode_e map_mode(input logic [2:0] code);
    case (code)
      3'd0:    return MD_FIX8;
      3'd1:    return MD_DUAL_CMP;
      3'd2:    return MD_FIX4;
      3'd3:    return MD_DUAL_EXACT;
      default: return MD_FULL;
    endcase
  endfunction

endpackage

// File: rtl/rfw_booth_enc.sv
module rfw_booth_enc
  import rfw_booth_pkg::*;
(
  input  logic [2:0] trip,
  output bdig_t      dig
);
  // trip = {b(2i+1), b(2i), b(2i-1)}
  always_comb begin
    dig.one = trip[1] ^ trip[0];
    dig.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    dig.neg = trip[2] & ~(trip[1] & trip[0]);
  end
endmodule

// File: rtl/rfw_booth_row.sv
module rfw_booth_row
  import rfw_booth_pkg::*;
#(
  parameter int PW  = 16,
  parameter int WSH = 0,
  parameter int NSH = 0,
  parameter int CW  = 5
) (
  input  bdig_t           dig,
  input  logic [PW-1:0]   mcand,
  input  logic            narrow,
  input  logic [CW-1:0]   cut,
  output logic [PW-1:0]   row
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] mag;
  logic [PW-1:0] val;
  logic [PW-1:0] shd;
  logic [PW-1:0] keep;

  always_comb begin
    if (dig.two)      mag = mcand << 1;
    else if (dig.one) mag = mcand;
    else              mag = '0;
    val = dig.neg ? (~mag + ONE) : mag;
    shd = narrow ? (val << NSH) : (val << WSH);
    for (int k = 0; k < PW; k++) keep[k] = (k >= int'(cut));
    row = shd & keep;
  end
endmodule

// File: rtl/rfw_booth_reduce.sv
module rfw_booth_reduce
  import rfw_booth_pkg::*;
#(
  parameter int W  = 8,
  parameter int H  = W / 2,
  parameter int ND = W / 2,
  parameter int PW = 2 * W
) (
  input  logic [ND-1:0][PW-1:0] rows,
  input  mode_e                 md,
  output logic [PW-1:0]         prod
);
  localparam int LR = ND / 2;
  localparam logic [PW-1:0] CMP_W = PW'((1 << W) - (1 << (W - 3)));
  localparam logic [W-1:0]  CMP_H = W'((1 << H) - (1 << (H - 3 > 0 ? H - 3 : 0)));

  logic [PW-1:0] s_all;
  logic [W-1:0]  s_lo;
  logic [W-1:0]  s_hi;
  logic [W-1:0]  r_all_c;
  logic [H-1:0]  r_lo_c;
  logic [H-1:0]  r_hi_c;

  always_comb begin
    s_all = '0;
    s_lo  = '0;
    s_hi  = '0;
    for (int i = 0; i < ND; i++) begin
      s_all = s_all + rows[i];
      if (i < LR) s_lo = s_lo + rows[i][W-1:0];
      else        s_hi = s_hi + rows[i][W-1:0];
    end
    r_all_c = W'((s_all + CMP_W) >> W);
    r_lo_c  = H'((s_lo + CMP_H) >> H);
    r_hi_c  = H'((s_hi + CMP_H) >> H);
    case (md)
      MD_FIX8:       prod = {{W{1'b0}}, r_all_c};
      MD_FIX4:       prod = {{(PW-H){1'b0}}, r_lo_c};
      MD_DUAL_CMP:   prod = {{W{1'b0}}, r_hi_c, r_lo_c};
      MD_DUAL_EXACT: prod = {{W{1'b0}}, s_hi[W-1:H], s_lo[W-1:H]};
      default:       prod = s_all;
    endcase
  end
endmodule

// File: rtl/rfw_booth_mul.sv
module rfw_booth_mul
  import rfw_booth_pkg::*;
#(
  parameter int W       = 8,
  parameter int REG_OUT = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       mode,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   prod,
  output logic             out_valid
);
  localparam int PW = 2 * W;
  localparam int H  = W / 2;
  localparam int ND = W / 2;
  localparam int LR = ND / 2;
  localparam int CW = $clog2(PW + 1);

  mode_e          md;
  logic           narrow;
  logic [CW-1:0]  cut;
  logic [PW-1:0]  mc_wide;
  logic [PW-1:0]  mc_lo;
  logic [PW-1:0]  mc_hi;
  logic [ND-1:0][PW-1:0] rows;
  logic [PW-1:0]  comb_prod;

  always_comb begin
    md      = map_mode(mode);
    narrow  = md inside {MD_DUAL_CMP, MD_FIX4, MD_DUAL_EXACT};
    if (md == MD_FIX8)                              cut = CW'(W - 2);
    else if (md == MD_FIX4 || md == MD_DUAL_CMP)    cut = CW'(H - 2);
    else                                            cut = '0;
    mc_wide = {{(PW-W){a[W-1]}}, a};
    mc_lo   = {{(PW-H){a[H-1]}}, a[H-1:0]};
    mc_hi   = {{(PW-H){a[W-1]}}, a[W-1:H]};
  end

  for (genvar g = 0; g < ND; g++) begin : g_row
    logic [2:0]    trip;
    logic [PW-1:0] mcand;
    bdig_t         dig;

    if (g == 0) begin : g_first
      assign trip = {b[1], b[0], 1'b0};
    end else if (g == LR) begin : g_split
      // Lane boundary: the high lane starts its own recoding in narrow modes.
      assign trip = {b[2*g+1], b[2*g], narrow ? 1'b0 : b[2*g-1]};
    end else begin : g_mid
      assign trip = {b[2*g+1], b[2*g], b[2*g-1]};
    end

    if (g < LR) begin : g_lo_lane
      assign mcand = narrow ? mc_lo : mc_wide;
    end else begin : g_hi_lane
      assign mcand = narrow ? mc_hi : mc_wide;
    end

    rfw_booth_enc u_enc (
      .trip (trip),
      .dig  (dig)
    );

    rfw_booth_row #(
      .PW  (PW),
      .WSH (2 * g),
      .NSH (2 * (g % LR)),
      .CW  (CW)
    ) u_row (
      .dig    (dig),
      .mcand  (mcand),
      .narrow (narrow),
      .cut    (cut),
      .row    (rows[g])
    );
  end

  rfw_booth_reduce #(
    .W  (W),
    .H  (H),
    .ND (ND),
    .PW (PW)
  ) u_reduce (
    .rows (rows),
    .md   (md),
    .prod (comb_prod)
  );

  if (REG_OUT != 0) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        prod      <= '0;
        out_valid <= 1'b0;
      end else begin
        prod      <= comb_prod;
        out_valid <= in_valid;
      end
    end
  end else begin : g_comb
    assign prod      = comb_prod;
    assign out_valid = in_valid;
  end
endmodule

// File: rtl/rfw_booth_mul_chk.sv
module rfw_booth_mul_chk #(
  parameter int W       = 8,
  parameter int REG_OUT = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [2:0]       mode,
  input logic [W-1:0]     a,
  input logic [W-1:0]     b,
  input logic [2*W-1:0]   prod,
  input logic             out_valid
);
  localparam int H = W / 2;

  logic signed [2*W-1:0] full_ref;
  logic signed [W-1:0]   lo_ref;
  logic signed [W-1:0]   hi_ref;
  logic signed [H-1:0]   lo_fl;
  logic signed [H-1:0]   hi_fl;

  assign full_ref = $signed(a) * $signed(b);
  assign lo_ref   = $signed(a[H-1:0]) * $signed(b[H-1:0]);
  assign hi_ref   = $signed(a[W-1:H]) * $signed(b[W-1:H]);
  assign lo_fl    = H'(lo_ref >>> H);
  assign hi_fl    = H'(hi_ref >>> H);

  if (REG_OUT != 0) begin : g_reg_chk
    assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && prod == '0));

    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (out_valid == $past(in_valid)));

    assert_full_exact_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd4) |=> (prod == $past(full_ref)));

    // R4: the spare codes alias the full-precision product
    assert_spare_code_R4: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode > 3'd4) |=> (prod == $past(full_ref)));

    assert_fix8_upper_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd0) |=> (prod[2*W-1:W] == '0));

    assert_zero_operand_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (a == '0 || b == '0)) |=> (prod == '0));

    assert_fix4_upper_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd2) |=> (prod[2*W-1:H] == '0));

    assert_dualcmp_upper_R8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd1) |=> (prod[2*W-1:W] == '0));

    assert_dual_floor_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mode == 3'd3) |=>
        (prod[H-1:0] == $past(lo_fl) && prod[W-1:H] == $past(hi_fl) &&
         prod[2*W-1:W] == '0));
  end
endmodule

bind rfw_booth_mul rfw_booth_mul_chk #(
  .W       (W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .a         (a),
  .b         (b),
  .prod      (prod),
  .out_valid (out_valid)
);

// File: tb/tb_rfw_booth_mul.sv
module tb_rfw_booth_mul;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  a = 8'h00;
  logic [7:0]  b = 8'h00;
  logic [15:0] prod;
  logic        out_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rfw_booth_mul #(.W(8), .REG_OUT(1)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .a(a), .b(b), .prod(prod), .out_valid(out_valid)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [7:0]  va;
    logic [7:0]  vb;
    logic [15:0] ex;
    logic [3:0]  rq;
  } vec_t;

  // Exact-result vectors (modes whose result is fully determined).
  localparam vec_t VT [12] = '{
    '{3'd4, 8'h7F, 8'h7F, 16'h3F01, 4'd3},  // R3 127*127
    '{3'd4, 8'h80, 8'h80, 16'h4000, 4'd3},  // R3 -128*-128
    '{3'd4, 8'h80, 8'h7F, 16'hC080, 4'd3},  // R3 -128*127
    '{3'd5, 8'h03, 8'hFB, 16'hFFF1, 4'd4},  // R4 3*-5
    '{3'd7, 8'hFF, 8'hFF, 16'h0001, 4'd4},  // R4 -1*-1
    '{3'd6, 8'h64, 8'hCE, 16'hEC78, 4'd4},  // R4 100*-50
    '{3'd3, 8'h7F, 8'h87, 16'h00CF, 4'd9},  // R9 lo -1*7, hi 7*-8
    '{3'd3, 8'h88, 8'h88, 16'h0044, 4'd9},  // R9 -8*-8 both lanes
    '{3'd3, 8'h35, 8'h47, 16'h0002, 4'd9},  // R9 lo 5*7, hi 3*4
    '{3'd0, 8'h00, 8'h5A, 16'h0000, 4'd6},  // R6 fixed 8-bit
    '{3'd1, 8'h00, 8'hFF, 16'h0000, 4'd6},  // R6 dual compensated
    '{3'd2, 8'hF0, 8'h77, 16'h0000, 4'd6}   // R6 single 4-bit, R7 upper ignored
  };

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic chk(input bit ok, input int req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d act=%0d exp=%0d (mode=%0d a=%h b=%h)", req, act, exp, mode, a, b);
    end
  endtask

  // Drive at a falling edge; the result is visible at the next falling edge.
  task automatic drive(input logic [2:0] m, input logic [7:0] x, input logic [7:0] y);
    mode = m; a = x; b = y; in_valid = 1'b1;
    @(negedge clk);
  endtask

  function automatic int lane_prod(input logic [3:0] x, input logic [3:0] y);
    int px, py;
    px = $signed(x);
    py = $signed(y);
    return px * py;
  endfunction

  function automatic bit bound16(input logic [3:0] r, input int p);
    int rv, e;
    rv = $signed(r);
    e = rv * 16 - p;
    return (e > -16) && (e < 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int p, r, e;
    logic [3:0] held;
    @(negedge clk);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(prod == 16'h0 && out_valid == 1'b0, 1, prod, 0);
    rst = 1'b0;

    for (int k = 0; k < 12; k++) begin
      drive(VT[k].md, VT[k].va, VT[k].vb);
      chk(prod == VT[k].ex && out_valid, int'(VT[k].rq), prod, VT[k].ex);
    end

    // R2: valid drops one cycle after in_valid drops
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, 2, out_valid, 0);
    drive(3'd4, 8'h05, 8'h06);
    chk(out_valid == 1'b1 && prod == 16'd30, 2, prod, 30);

    // R3: exhaustive full precision
    for (int i = 0; i < 65536; i++) begin
      drive(3'd4, i[15:8], i[7:0]);
      p = $signed(a) * $signed(b);
      chk(prod == p[15:0], 3, prod, p[15:0]);
    end

    // R5: exhaustive 8-bit fixed-width, error under one LSB
    for (int i = 0; i < 65536; i++) begin
      drive(3'd0, i[7:0], i[15:8]);
      p = $signed(a) * $signed(b);
      r = $signed(prod[7:0]);
      e = r * 256 - p;
      chk(prod[15:8] == 8'h0 && e > -256 && e < 256, 5, r * 256, p);
    end

    // R8 and R9: each lane over all nibble pairs, other lane permuted
    for (int i = 0; i < 256; i++) begin
      int j;
      logic [7:0] jj, ii;
      j = (i * 37 + 11) & 255;
      jj = j[7:0];
      ii = i[7:0];
      drive(3'd1, {jj[3:0], ii[3:0]}, {jj[7:4], ii[7:4]});
      chk(prod[15:8] == 8'h0 &&
          bound16(prod[3:0], lane_prod(a[3:0], b[3:0])) &&
          bound16(prod[7:4], lane_prod(a[7:4], b[7:4])), 8, prod, lane_prod(a[3:0], b[3:0]));
      drive(3'd3, {jj[3:0], ii[3:0]}, {jj[7:4], ii[7:4]});
      p = lane_prod(a[3:0], b[3:0]) >>> 4;
      r = lane_prod(a[7:4], b[7:4]) >>> 4;
      chk(prod[15:8] == 8'h0 && prod[3:0] == p[3:0] && prod[7:4] == r[3:0], 9,
          prod, {r[3:0], p[3:0]});
    end

    // R7: single 4-bit product, upper nibbles are noise
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ii, jj;
      int j;
      j = (i * 53 + 7) & 255;
      ii = i[7:0];
      jj = j[7:0];
      drive(3'd2, {jj[3:0], ii[3:0]}, {jj[7:4], ii[7:4]});
      chk(prod[15:4] == 12'h0 && bound16(prod[3:0], lane_prod(a[3:0], b[3:0])), 7,
          prod, lane_prod(a[3:0], b[3:0]));
    end

    // R4: spare codes over scattered operands
    for (int i = 0; i < 768; i++) begin
      logic [15:0] v;
      v = 16'((i * 40503 + 12345) & 65535);
      drive(3'(5 + (i % 3)), v[15:8], v[7:0]);
      p = $signed(a) * $signed(b);
      chk(prod == p[15:0], 4, prod, p[15:0]);
    end

    // R10: hold the low lane, sweep the high lane (both dual modes)
    drive(3'd1, 8'h05, 8'h0D);
    held = prod[3:0];
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ii;
      ii = i[7:0];
      drive(3'd1, {ii[3:0], 4'h5}, {ii[7:4], 4'hD});
      chk(prod[3:0] == held, 10, prod[3:0], held);
    end
    for (int i = 0; i < 256; i++) begin
      logic [7:0] ii;
      ii = i[7:0];
      drive(3'd3, {4'h9, ii[3:0]}, {4'hA, ii[7:4]});
      chk(prod[7:4] == 4'h2, 10, prod[7:4], 2);  // -7*-6=42, floor(42/16)=2
    end

    // R1: reset while a request is presented
    drive(3'd4, 8'h7F, 8'h7F);
    rst = 1'b1;
    @(negedge clk);
    chk(prod == 16'h0 && out_valid == 1'b0, 1, prod, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule